// File: doc/BRIEF.md
# Gated Ring Oscillator Time-to-Digital Converter Readout

This block is the digital back-end of a time-to-digital converter built around a gated ring oscillator. It is used to measure the time between a reference edge and a feedback edge of a locked loop. Both edges arrive as single-cycle event pulses in the readout clock domain. The first of the two pulses opens a gating window. The second one closes it. The block drives the gate output that lets the ring oscillate, and it records which edge came first as a sign bit.

The outputs of all ring stages arrive as an input vector. While the window is open, every stage has its own counter that counts the transitions seen on that stage. When the window closes, the counts of all stages are added into one offset code, and the code is marked by a one-cycle valid strobe. Because the ring stops rather than being reset between windows, each measurement starts from the phase the ring held at the end of the previous one. Only transitions are counted, never absolute phase. Adding the counts of all stages spreads the stage mismatch across the measurements. The per-stage counters clear when a window opens. The per-stage counts and the summed code both saturate instead of wrapping.

Top module: `grotdc_readout`

## Requirements
- R1: While reset is active, `gate_o`, `valid_o`, `code_o` and `fb_lead_o` are all 0.
- R2: When exactly one of `ref_pulse_i`/`fb_pulse_i` is 1 in an idle cycle, `gate_o` rises after that clock edge. It stays 1 until the clock edge that samples the other pulse, then falls. It is therefore high for exactly as many cycles as separate the two pulses.
- R3: `fb_lead_o` is 1 when the feedback pulse opened the window. It is 0 when the reference pulse opened it, or when both pulses arrived in the same cycle.
- R4: `code_o` equals the sum over all stages of the number of changes of that stage's `ring_phase_i` bit, sampled at the clock edges where `gate_o` is 1. Each stage's contribution is limited to 2^STAGE_CNT_W-1.
- R5: Changes of `ring_phase_i` at edges where `gate_o` is 0 are not counted. Counts from one window do not carry into the next.
- R6: `valid_o` is high for exactly one cycle: the second cycle after the clock edge that sampled the closing pulse. `code_o` and `fb_lead_o` change only as `valid_o` rises, and hold until the next strobe.
- R7: The summed code saturates at 2^SUM_W-1 instead of wrapping.
- R8: If both pulses are 1 in the same idle cycle, the window never opens (`gate_o` stays 0). A result with code 0 and sign 0 is still reported, with the same two-cycle latency.
- R9: While the window is open, further pulses of the edge that opened it have no effect on the window length or the sign.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Readout clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| ref_pulse_i | input | 1 | One-cycle event: reference edge arrived |
| fb_pulse_i | input | 1 | One-cycle event: feedback edge arrived |
| ring_phase_i | input | NUM_STAGES | Outputs of the oscillator stages |
| gate_o | output | 1 | Gating window; the ring runs while this is 1 |
| code_o | output | SUM_W | Summed transition count of the last window |
| fb_lead_o | output | 1 | 1 when the feedback edge led in the last window |
| valid_o | output | 1 | One-cycle strobe: new code and sign |

## Verification
The bench builds the block with 5 stages, 4-bit stage counters and a 6-bit sum, so both saturation limits (15 per stage, 63 summed) fall inside short windows. It sweeps both edge orders, every window length from 1 to 24 cycles, and 1 to 3 ring transitions per cycle. The ring is modelled as a walking toggle whose phase is held between windows. A separate run hammers a single stage to reach per-stage saturation. Toggles are injected while the gate is closed, and repeated opening pulses are sent inside windows, so that the ignore rules and the zero-length window are covered as well.

// File: rtl/grotdc_pkg.sv
package grotdc_pkg;
  typedef enum logic [1:0] {
    WIN_IDLE   = 2'd0,
    WIN_OPEN   = 2'd1,
    WIN_REPORT = 2'd2
  } win_state_e;
endpackage

// File: rtl/grotdc_window.sv
module grotdc_window
  import grotdc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic ref_pulse_i,
  input  logic fb_pulse_i,
  output logic gate_o,
  output logic clr_o,
  output logic load_o,
  output logic lead_o
);
  win_state_e state_q, state_d;
  logic       lead_q, lead_d;
  logic       close_evt;

  // The edge that did not open the window is the one that closes it.
  assign close_evt = lead_q ? ref_pulse_i : fb_pulse_i;

  always_comb begin
    state_d = state_q;
    lead_d  = lead_q;
    clr_o   = 1'b0;
    unique case (state_q)
      WIN_IDLE: begin
        if (ref_pulse_i && fb_pulse_i) begin
          state_d = WIN_REPORT;
          lead_d  = 1'b0;
          clr_o   = 1'b1;
        end else if (ref_pulse_i || fb_pulse_i) begin
          state_d = WIN_OPEN;
          lead_d  = fb_pulse_i;
          clr_o   = 1'b1;
        end
      end
      WIN_OPEN: begin
        if (close_evt) state_d = WIN_REPORT;
      end
      WIN_REPORT: state_d = WIN_IDLE;
      default:    state_d = WIN_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= WIN_IDLE;
      lead_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      lead_q  <= lead_d;
    end
  end

  assign gate_o = (state_q == WIN_OPEN);
  assign load_o = (state_q == WIN_REPORT);
  assign lead_o = lead_q;

  // R2
  gate_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(gate_o) |-> $past(ref_pulse_i || fb_pulse_i));
  // R2
  gate_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gate_o) |-> $past(ref_pulse_i ^ fb_pulse_i));
  // R9
  lead_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_o && $past(gate_o)) |-> $stable(lead_o));
endmodule

// File: rtl/grotdc_stage_cnt.sv
module grotdc_stage_cnt #(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             phase_i,
  input  logic             count_en_i,
  input  logic             clr_i,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic             phase_q;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             toggled;

  assign toggled = phase_i ^ phase_q;

  always_comb begin
    cnt_d = cnt_q;
    if (clr_i)
      cnt_d = '0;
    else if (count_en_i && toggled && (cnt_q != CNT_MAX))
      cnt_d = cnt_q + 1'b1;
  end

  // The previous phase follows the ring every cycle, so the held phase
  // becomes the reference for the next window.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= 1'b0;
      cnt_q   <= '0;
    end else begin
      phase_q <= phase_i;
      cnt_q   <= cnt_d;
    end
  end

  assign cnt_o = cnt_q;

  // R5
  closed_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_i && !count_en_i) |=> $stable(cnt_o));
  // R4
  stage_nowrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_i |=> (cnt_o >= $past(cnt_o)));
endmodule

// File: rtl/grotdc_summer.sv
module grotdc_summer #(
  parameter int NUM_STAGES  = 21,
  parameter int STAGE_CNT_W = 5,
  parameter int SUM_W       = 9
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          load_i,
  input  logic                          lead_i,
  input  logic [NUM_STAGES*STAGE_CNT_W-1:0] cnt_flat_i,
  output logic [SUM_W-1:0]              code_o,
  output logic                          sign_o,
  output logic                          valid_o
);
  localparam int RAW_W = STAGE_CNT_W + $clog2(NUM_STAGES) + 1;
  localparam int ACC_W = (RAW_W > SUM_W) ? RAW_W : SUM_W;
  localparam logic [ACC_W-1:0] SAT = ACC_W'({SUM_W{1'b1}});

  logic [ACC_W-1:0] acc;
  logic [SUM_W-1:0] sum_sat;
  logic [SUM_W-1:0] code_q, code_d;
  logic             sign_q, sign_d;
  logic             valid_q;

  always_comb begin
    acc = '0;
    for (int i = 0; i < NUM_STAGES; i++)
      acc = acc + ACC_W'(cnt_flat_i[i*STAGE_CNT_W +: STAGE_CNT_W]);
  end

  assign sum_sat = (acc > SAT) ? {SUM_W{1'b1}} : acc[SUM_W-1:0];

  always_comb begin
    code_d = code_q;
    sign_d = sign_q;
    if (load_i) begin
      code_d = sum_sat;
      sign_d = lead_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q  <= '0;
      sign_q  <= 1'b0;
      valid_q <= 1'b0;
    end else begin
      code_q  <= code_d;
      sign_q  <= sign_d;
      valid_q <= load_i;
    end
  end

  assign code_o  = code_q;
  assign sign_o  = sign_q;
  assign valid_o = valid_q;

  // R6
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |=> !valid_o);
  // R6
  code_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_o |-> ($stable(code_o) && $stable(sign_o)));
endmodule

// File: rtl/grotdc_readout.sv
module grotdc_readout #(
  parameter int NUM_STAGES  = 21,
  parameter int STAGE_CNT_W = 5,
  parameter int SUM_W       = 9
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  ref_pulse_i,
  input  logic                  fb_pulse_i,
  input  logic [NUM_STAGES-1:0] ring_phase_i,
  output logic                  gate_o,
  output logic [SUM_W-1:0]      code_o,
  output logic                  fb_lead_o,
  output logic                  valid_o
);
  localparam int FLAT_W = NUM_STAGES * STAGE_CNT_W;

  logic [1:0]        rst_sync_q;
  logic              rst_int_n;
  logic              win_gate, win_clr, win_load, win_lead;
  logic [FLAT_W-1:0] cnt_flat;

  // Reset asserts at once and releases on the second clock edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  grotdc_window u_window (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .ref_pulse_i (ref_pulse_i),
    .fb_pulse_i  (fb_pulse_i),
    .gate_o      (win_gate),
    .clr_o       (win_clr),
    .load_o      (win_load),
    .lead_o      (win_lead)
  );

  for (genvar g = 0; g < NUM_STAGES; g++) begin : g_stage
    grotdc_stage_cnt #(.CNT_W(STAGE_CNT_W)) u_cnt (
      .clk        (clk),
      .rst_n      (rst_int_n),
      .phase_i    (ring_phase_i[g]),
      .count_en_i (win_gate),
      .clr_i      (win_clr),
      .cnt_o      (cnt_flat[g*STAGE_CNT_W +: STAGE_CNT_W])
    );
  end

  grotdc_summer #(
    .NUM_STAGES  (NUM_STAGES),
    .STAGE_CNT_W (STAGE_CNT_W),
    .SUM_W       (SUM_W)
  ) u_summer (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .load_i     (win_load),
    .lead_i     (win_lead),
    .cnt_flat_i (cnt_flat),
    .code_o     (code_o),
    .sign_o     (fb_lead_o),
    .valid_o    (valid_o)
  );

  assign gate_o = win_gate;

  // R6
  valid_after_close_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    valid_o |-> ($past(!gate_o) && !gate_o));
  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_int_n |-> (!gate_o && !valid_o));
endmodule

// File: tb/grotdc_readout_tb.sv
module grotdc_readout_tb;
  localparam int N    = 5;
  localparam int CW   = 4;
  localparam int SW   = 6;
  localparam int SMAX = (1 << CW) - 1;
  localparam int TMAX = (1 << SW) - 1;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          ref_p, fb_p;
  logic [N-1:0]  phase;
  logic          gate_o, fb_lead_o, valid_o;
  logic [SW-1:0] code_o;

  int tests = 0, fails = 0;
  int flips[N];
  int ptr = 0;
  int gate_cnt;
  bit done = 0;

  always #2 clk = ~clk;

  grotdc_readout #(.NUM_STAGES(N), .STAGE_CNT_W(CW), .SUM_W(SW)) u_dut (
    .clk(clk), .rst_n(rst_n), .ref_pulse_i(ref_p), .fb_pulse_i(fb_p),
    .ring_phase_i(phase), .gate_o(gate_o), .code_o(code_o),
    .fb_lead_o(fb_lead_o), .valid_o(valid_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // One cycle: clear pulses, and if the gate is open the ring moves.
  task automatic tick(input int k, input bit single);
    @(negedge clk);
    ref_p = 1'b0;
    fb_p  = 1'b0;
    if (gate_o) begin
      gate_cnt++;
      for (int j = 0; j < k; j++) begin
        int idx;
        idx = single ? 0 : ptr;
        phase[idx] = ~phase[idx];
        flips[idx]++;
        if (!single) ptr = (ptr + 1) % N;
      end
    end
  endtask

  // Toggles while the gate is closed must not be counted (R5).
  task automatic idle_tick(input int k);
    @(negedge clk);
    ref_p = 1'b0;
    fb_p  = 1'b0;
    for (int j = 0; j < k; j++) begin
      phase[ptr] = ~phase[ptr];
      ptr = (ptr + 1) % N;
    end
  endtask

  function automatic int expect_code();
    int e = 0;
    for (int i = 0; i < N; i++) e += (flips[i] > SMAX) ? SMAX : flips[i];
    return (e > TMAX) ? TMAX : e;
  endfunction

  task automatic measure(input bit fb_first, input int n, input int k,
                         input bit single, input bit extra);
    int e;
    idle_tick(2);
    idle_tick(1);
    tick(0, 0);
    for (int i = 0; i < N; i++) flips[i] = 0;
    gate_cnt = 0;
    if (fb_first) fb_p = 1'b1; else ref_p = 1'b1;
    for (int i = 1; i <= n; i++) begin
      tick(k, single);
      if (i == n) begin
        if (fb_first) ref_p = 1'b1; else fb_p = 1'b1;
      end else if (extra && i == 1) begin
        // R9: repeated opening pulse inside the window
        if (fb_first) fb_p = 1'b1; else ref_p = 1'b1;
      end
    end
    e = expect_code();
    tick(0, 0);
    chk(valid_o == 1'b0 && gate_o == 1'b0, "R6 valid low one cycle after close", valid_o, 0);
    tick(0, 0);
    chk(valid_o == 1'b1, "R6 valid on second cycle", valid_o, 1);
    chk(int'(code_o) == e, single ? "R4 stage saturation" :
        (e == TMAX ? "R7 sum saturation" : "R4 summed count"), code_o, e);
    chk(fb_lead_o == fb_first, "R3 sign", fb_lead_o, fb_first);
    chk(gate_cnt == n, extra ? "R9 window length with extra pulse" : "R2 window length",
        gate_cnt, n);
    tick(0, 0);
    chk(valid_o == 1'b0, "R6 valid single cycle", valid_o, 0);
    chk(int'(code_o) == e, "R6 code held", code_o, e);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    ref_p = 1'b0;
    fb_p  = 1'b0;
    phase = '0;
    repeat (3) @(negedge clk);
    // R1: a pulse during reset must not open a window
    ref_p = 1'b1;
    @(negedge clk);
    ref_p = 1'b0;
    chk(gate_o == 0 && valid_o == 0 && code_o == 0 && fb_lead_o == 0,
        "R1 reset outputs", {gate_o, valid_o, fb_lead_o}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(gate_o == 0 && valid_o == 0, "R1 quiet after release", {gate_o, valid_o}, 0);

    for (int f = 0; f < 2; f++)
      for (int n = 1; n <= 24; n++)
        for (int k = 1; k <= 3; k++)
          measure(f[0], n, k, 1'b0, (n >= 3) && (k == 2));

    // R4: one stage hammered past its counter limit
    measure(1'b1, 20, 1, 1'b1, 1'b0);
    measure(1'b0, 9, 1, 1'b1, 1'b0);

    // R8: both edges in the same cycle, after a nonzero result
    measure(1'b1, 6, 1, 1'b0, 1'b0);
    tick(0, 0);
    ref_p = 1'b1;
    fb_p  = 1'b1;
    tick(0, 0);
    chk(gate_o == 0 && valid_o == 0, "R8 gate stays closed", gate_o, 0);
    idle_tick(2);
    chk(valid_o == 1, "R8 valid latency", valid_o, 1);
    chk(code_o == 0, "R8 zero code", code_o, 0);
    chk(fb_lead_o == 0, "R8 sign zero", fb_lead_o, 0);
    chk(gate_o == 0, "R8 gate never opened", gate_o, 0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule